// File: doc/BRIEF.md
# Power-Mode Clock Gating Controller

This block decides, once per system clock cycle, which clock domains of a small microcontroller are allowed to toggle. It holds three pieces of software configuration: a peripheral enable mask, a peripheral force mask and a control word with a low-power enable and a missing-clock-detector enable. It combines them with the current power state (running, idle or stopped) to produce one enable for the CPU clock, one per peripheral domain and one for the precision oscillator. Each enable is re-timed on the falling edge of the system clock, so a downstream AND-type gate only sees enable changes while the clock is low.

Software enters idle or stop by writing the mode register. An enabled wake or interrupt input ends idle. Stop ends only through a reset: either the external reset or an internal reset pulse that the block raises when the missing-clock detector reports a timeout while its enable bit is set. The internal reset returns every register of the block to its reset value, one cycle after the pulse appears.

Top module: `pmclk_ctrl`

Register addresses (`wr_addr_i`): 0 = enable mask, 1 = force mask, 2 = control (bit 0 low-power enable, bit 1 missing-clock-detector enable), 3 = mode (bit 0 idle request, bit 1 stop request). Peripheral enable bit order: 0 pulse counter, 1 real-time clock, 2 timers 0 to 2, 3 timer 3, 4 UART, 5 SMBus, 6 power management unit, 7 CRC, 8 ADC, 9 PCA, 10 SPI.

## Requirements
- R1: While reset is asserted and after it is released, the CPU enable, every peripheral enable and the oscillator enable are 1, `int_rst_o` and `mcd_en_o` are 0, the enable mask is all ones, the force mask is all zeros and the control bits are 0.
- R2: With the low-power bit (control bit 0) clear, a write of 1 to mode bit 0 gates the CPU enable to 0 from the cycle after the write while every peripheral enable stays 1.
- R3: With the low-power bit set and the block idle, the CPU enable is 0 and each peripheral enable equals its bit in the enable mask; the force mask has no effect.
- R4: With the low-power bit set and the CPU running, the CPU enable is 1 and each peripheral enable is the OR of its enable-mask bit and force-mask bit.
- R5: With the low-power bit set, the CPU running and the force mask at zero, each peripheral enable equals its enable-mask bit.
- R6: With the low-power bit clear and the CPU running, the CPU enable and every peripheral enable are 1 whatever the mask contents.
- R7: A wake input sampled high at a clock edge while idle restores the CPU enable to 1 from that edge on.
- R8: A write of 1 to mode bit 1 leaves all enables unchanged for the cycle after the write; from the following edge the CPU, all peripheral and the oscillator enables are 0.
- R9: Once stopped, the wake input and further mode writes do not change any enable.
- R10: A timeout sampled high while control bit 1 is set raises `int_rst_o` for exactly one cycle, after which all state is back at its R1 values; with control bit 1 clear a timeout has no effect.
- R11: Asserting the external reset while stopped restores all enables to 1.
- R12: Enables change only at the falling clock edge: the values just after a rising edge equal those just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | NUM_PERIPH | Write data |
| wake_i | input | 1 | Enabled interrupt or wake request |
| mcd_timeout_i | input | 1 | Timeout flag from the missing-clock detector |
| cpu_clk_en_o | output | 1 | CPU clock enable, falling-edge timed |
| periph_clk_en_o | output | NUM_PERIPH | Peripheral clock enables, falling-edge timed |
| osc_en_o | output | 1 | Precision oscillator enable |
| mcd_en_o | output | 1 | Enable hook for the missing-clock detector |
| int_rst_o | output | 1 | One-cycle internal reset pulse |

## Verification
The assertions assume the write strobe, wake and timeout inputs change only away from the rising edge and are otherwise unconstrained, and they excuse the one cycle in which the internal reset is pending, since that cycle overrides every other transition. The bench drives every input just after a rising edge and reads the enables just after the following falling edge, so every check lands on a settled value. The mask sweep covers both settings of the low-power bit with and without idle over forty computed mask pairs, including zero force masks, so standard and low-power gating are both exercised with varied bit patterns.

// File: rtl/pmclk_pkg.sv
package pmclk_pkg;

    // Register addresses; software depends on this map.
    typedef enum logic [1:0] {
        ADDR_EN_MASK  = 2'd0,
        ADDR_FRC_MASK = 2'd1,
        ADDR_CTRL     = 2'd2,
        ADDR_MODE     = 2'd3
    } pmclk_addr_e;

    // Control register bit positions
    localparam int CTRL_LP_BIT  = 0;
    localparam int CTRL_MCD_BIT = 1;

    // Mode register bit positions
    localparam int MODE_IDLE_BIT = 0;
    localparam int MODE_STOP_BIT = 1;

    // Power state as seen by the gate bank
    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_IDLE = 2'd1,
        PS_STOP = 2'd2
    } pmclk_pstate_e;

endpackage

// File: rtl/pmclk_regs.sv
module pmclk_regs
    import pmclk_pkg::*;
#(
    parameter int NUM_PERIPH = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  srst,
    input  logic                  stopped,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [NUM_PERIPH-1:0] wr_data,
    output logic [NUM_PERIPH-1:0] en_mask,
    output logic [NUM_PERIPH-1:0] frc_mask,
    output logic                  lp_en,
    output logic                  mcd_en,
    output logic                  idle_req,
    output logic                  stop_req
);

    localparam logic [NUM_PERIPH-1:0] EN_RESET  = {NUM_PERIPH{1'b1}};
    localparam logic [NUM_PERIPH-1:0] FRC_RESET = '0;

    typedef struct packed {
        logic [NUM_PERIPH-1:0] en;
        logic [NUM_PERIPH-1:0] frc;
        logic                  lp;
        logic                  mcd;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{en: EN_RESET, frc: FRC_RESET, lp: 1'b0, mcd: 1'b0};

    cfg_t        cfg_d, cfg_q;
    pmclk_addr_e addr;
    logic        wr_ok;

    assign addr  = pmclk_addr_e'(wr_addr);
    // The CPU is halted while stopped, so no write can land then.
    assign wr_ok = wr_en && !stopped;

    always_comb begin
        cfg_d = cfg_q;
        if (srst) begin
            cfg_d = CFG_RESET;
        end else if (wr_ok) begin
            unique case (addr)
                ADDR_EN_MASK:  cfg_d.en  = wr_data;
                ADDR_FRC_MASK: cfg_d.frc = wr_data;
                ADDR_CTRL: begin
                    cfg_d.lp  = wr_data[CTRL_LP_BIT];
                    cfg_d.mcd = wr_data[CTRL_MCD_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign en_mask  = cfg_q.en;
    assign frc_mask = cfg_q.frc;
    assign lp_en    = cfg_q.lp;
    assign mcd_en   = cfg_q.mcd;
    assign idle_req = wr_ok && !srst && (addr == ADDR_MODE) && wr_data[MODE_IDLE_BIT];
    assign stop_req = wr_ok && !srst && (addr == ADDR_MODE) && wr_data[MODE_STOP_BIT];

    // Internal reset restores every configuration field on the next edge.
    assert_soft_reset_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (en_mask == EN_RESET && frc_mask == FRC_RESET && !lp_en && !mcd_en));

    // No mode request can be generated while stopped.
    assert_no_req_in_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (!idle_req && !stop_req));

endmodule

// File: rtl/pmclk_mode.sv
module pmclk_mode
    import pmclk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle_req,
    input  logic          stop_req,
    input  logic          wake_i,
    input  logic          mcd_en,
    input  logic          mcd_timeout,
    output pmclk_pstate_e pstate,
    output logic          stopped,
    output logic          srst
);

    typedef struct packed {
        logic idle;
        logic stop_pend;
        logic stop;
        logic rst_req;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (mode_q.rst_req) begin
            mode_d = '0;
        end else begin
            // Stop lands one cycle after the accepted write.
            if (mode_q.stop_pend) mode_d.stop = 1'b1;
            mode_d.stop_pend = stop_req;
            if (wake_i)   mode_d.idle = 1'b0;
            if (idle_req) mode_d.idle = 1'b1;
            mode_d.rst_req = mcd_en && mcd_timeout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    always_comb begin
        if (mode_q.stop)      pstate = PS_STOP;
        else if (mode_q.idle) pstate = PS_IDLE;
        else                  pstate = PS_RUN;
    end

    assign stopped = mode_q.stop;
    assign srst    = mode_q.rst_req;

    assert_stop_after_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.stop_pend && !mode_q.rst_req) |=> mode_q.stop);

    assert_stop_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.stop && !mode_q.rst_req) |=> mode_q.stop);

    assert_wake_ends_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.idle && wake_i && !idle_req) |=> !mode_q.idle);

    assert_int_reset_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.rst_req |=> (!mode_q.rst_req && !mode_q.stop && !mode_q.idle));

endmodule

// File: rtl/pmclk_gate_bank.sv
module pmclk_gate_bank
    import pmclk_pkg::*;
#(
    parameter int NUM_PERIPH = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pmclk_pstate_e         pstate,
    input  logic                  lp_en,
    input  logic [NUM_PERIPH-1:0] en_mask,
    input  logic [NUM_PERIPH-1:0] frc_mask,
    output logic                  cpu_en,
    output logic [NUM_PERIPH-1:0] periph_en,
    output logic                  osc_en
);

    localparam logic [NUM_PERIPH-1:0] ALL_ON = {NUM_PERIPH{1'b1}};

    logic                  cpu_want;
    logic                  osc_want;
    logic [NUM_PERIPH-1:0] periph_want;

    always_comb begin
        cpu_want    = 1'b1;
        osc_want    = 1'b1;
        periph_want = ALL_ON;
        unique case (pstate)
            PS_STOP: begin
                cpu_want    = 1'b0;
                osc_want    = 1'b0;
                periph_want = '0;
            end
            PS_IDLE: begin
                cpu_want    = 1'b0;
                periph_want = lp_en ? en_mask : ALL_ON;
            end
            default: begin
                periph_want = lp_en ? (en_mask | frc_mask) : ALL_ON;
            end
        endcase
    end

    // Falling-edge enable flops: a gate sees a new enable only while clk is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_en <= 1'b1;
            osc_en <= 1'b1;
        end else begin
            cpu_en <= cpu_want;
            osc_en <= osc_want;
        end
    end

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_dom
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) periph_en[g] <= 1'b1;
            else        periph_en[g] <= periph_want[g];
        end
    end

    assert_stop_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_STOP) |-> (!cpu_en && !osc_en && periph_en == '0));

    assert_lp_idle_follows_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_IDLE && lp_en) |-> (!cpu_en && periph_en == en_mask));

    assert_std_idle_keeps_periph_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_IDLE && !lp_en) |-> (!cpu_en && periph_en == ALL_ON));

    assert_cpu_on_when_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_RUN) |-> (cpu_en && osc_en));

endmodule

// File: rtl/pmclk_ctrl.sv
module pmclk_ctrl
    import pmclk_pkg::*;
#(
    parameter int NUM_PERIPH = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_addr_i,
    input  logic [NUM_PERIPH-1:0] wr_data_i,
    input  logic                  wake_i,
    input  logic                  mcd_timeout_i,
    output logic                  cpu_clk_en_o,
    output logic [NUM_PERIPH-1:0] periph_clk_en_o,
    output logic                  osc_en_o,
    output logic                  mcd_en_o,
    output logic                  int_rst_o
);

    logic [NUM_PERIPH-1:0] en_mask;
    logic [NUM_PERIPH-1:0] frc_mask;
    logic                  lp_en;
    logic                  mcd_en;
    logic                  idle_req;
    logic                  stop_req;
    logic                  stopped;
    logic                  srst;
    pmclk_pstate_e         pstate;

    pmclk_regs #(.NUM_PERIPH(NUM_PERIPH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .stopped  (stopped),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .en_mask  (en_mask),
        .frc_mask (frc_mask),
        .lp_en    (lp_en),
        .mcd_en   (mcd_en),
        .idle_req (idle_req),
        .stop_req (stop_req)
    );

    pmclk_mode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_req    (idle_req),
        .stop_req    (stop_req),
        .wake_i      (wake_i),
        .mcd_en      (mcd_en),
        .mcd_timeout (mcd_timeout_i),
        .pstate      (pstate),
        .stopped     (stopped),
        .srst        (srst)
    );

    pmclk_gate_bank #(.NUM_PERIPH(NUM_PERIPH)) u_gates (
        .clk       (clk),
        .rst_n     (rst_n),
        .pstate    (pstate),
        .lp_en     (lp_en),
        .en_mask   (en_mask),
        .frc_mask  (frc_mask),
        .cpu_en    (cpu_clk_en_o),
        .periph_en (periph_clk_en_o),
        .osc_en    (osc_en_o)
    );

    assign mcd_en_o  = mcd_en;
    assign int_rst_o = srst;

    // Without the detector enabled, no internal reset can appear.
    assert_mcd_gates_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mcd_en_o |=> !int_rst_o);

endmodule

// File: tb/pmclk_ctrl_test.sv
module pmclk_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 11;
    localparam logic [NP-1:0] ALL = {NP{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [1:0]    wr_addr_i = '0;
    logic [NP-1:0] wr_data_i = '0;
    logic          wake_i = 1'b0;
    logic          mcd_timeout_i = 1'b0;
    logic          cpu_clk_en_o;
    logic [NP-1:0] periph_clk_en_o;
    logic          osc_en_o;
    logic          mcd_en_o;
    logic          int_rst_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmclk_ctrl #(.NUM_PERIPH(NP)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en_i         (wr_en_i),
        .wr_addr_i       (wr_addr_i),
        .wr_data_i       (wr_data_i),
        .wake_i          (wake_i),
        .mcd_timeout_i   (mcd_timeout_i),
        .cpu_clk_en_o    (cpu_clk_en_o),
        .periph_clk_en_o (periph_clk_en_o),
        .osc_en_o        (osc_en_o),
        .mcd_en_o        (mcd_en_o),
        .int_rst_o       (int_rst_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic settle;
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [NP-1:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    function automatic logic [NP-1:0] exp_periph(input bit lp, input bit idle,
                                                 input logic [NP-1:0] en,
                                                 input logic [NP-1:0] frc);
        if (!lp)  return ALL;
        if (idle) return en;
        return en | frc;
    endfunction

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual hang expected completion");
                finish_run();
            end
        end
    end

    initial begin
        logic [NP-1:0] en, frc, pre_p;
        logic          pre_c;

        // R1: reset state, during and after reset
        repeat (3) tick();
        check("R1", "cpu in reset", 32'(cpu_clk_en_o), 32'd1);
        check("R1", "periph in reset", 32'(periph_clk_en_o), 32'(ALL));
        rst_n = 1'b1;
        tick(); settle();
        check("R1", "cpu", 32'(cpu_clk_en_o), 32'd1);
        check("R1", "periph", 32'(periph_clk_en_o), 32'(ALL));
        check("R1", "osc", 32'(osc_en_o), 32'd1);
        check("R1", "int_rst", 32'(int_rst_o), 32'd0);
        check("R1", "mcd_en", 32'(mcd_en_o), 32'd0);

        // Sweep masks over both low-power settings, running and idle
        for (int i = 0; i < 40; i++) begin
            en  = NP'((i * 32'h2C5 + 32'h13) ^ (i << 6));
            frc = (i % 4 == 0) ? '0 : NP'((i * 32'h1A7) ^ 32'h555);
            for (int lp = 0; lp < 2; lp++) begin
                for (int idle = 0; idle < 2; idle++) begin
                    wr(2'd0, en);
                    wr(2'd1, frc);
                    wr(2'd2, NP'(lp));
                    if (idle == 1) wr(2'd3, NP'(1));
                    settle();
                    if (lp == 0 && idle == 0) begin
                        check("R6", "periph", 32'(periph_clk_en_o), 32'(ALL));
                        check("R6", "cpu", 32'(cpu_clk_en_o), 32'd1);
                    end else if (lp == 0) begin
                        check("R2", "periph", 32'(periph_clk_en_o), 32'(ALL));
                        check("R2", "cpu", 32'(cpu_clk_en_o), 32'd0);
                    end else if (idle == 1) begin
                        check("R3", "periph", 32'(periph_clk_en_o), 32'(exp_periph(1, 1, en, frc)));
                        check("R3", "cpu", 32'(cpu_clk_en_o), 32'd0);
                    end else if (frc == '0) begin
                        check("R5", "periph", 32'(periph_clk_en_o), 32'(en));
                        check("R5", "cpu", 32'(cpu_clk_en_o), 32'd1);
                    end else begin
                        check("R4", "periph", 32'(periph_clk_en_o), 32'(exp_periph(1, 0, en, frc)));
                        check("R4", "cpu", 32'(cpu_clk_en_o), 32'd1);
                    end
                    if (idle == 1) begin
                        wake_i = 1'b1; tick(); wake_i = 1'b0;
                        settle();
                        check("R7", "cpu after wake", 32'(cpu_clk_en_o), 32'd1);
                        check("R7", "periph after wake", 32'(periph_clk_en_o),
                              32'(exp_periph(lp[0], 0, en, frc)));
                    end
                end
            end
        end

        // R12: enables hold across the rising edge that accepts a change
        wr(2'd1, '0);
        wr(2'd0, NP'(11'h0F0));
        settle();
        pre_p = periph_clk_en_o;
        wr(2'd0, NP'(11'h70F));
        check("R12", "periph just after rise", 32'(periph_clk_en_o), 32'(pre_p));
        settle();
        check("R12", "periph after fall", 32'(periph_clk_en_o), 32'h70F);
        pre_c = cpu_clk_en_o;
        wr(2'd3, NP'(1));
        check("R12", "cpu just after rise", 32'(cpu_clk_en_o), 32'(pre_c));
        settle();
        check("R12", "cpu after fall", 32'(cpu_clk_en_o), 32'd0);
        wake_i = 1'b1; tick(); wake_i = 1'b0;

        // R10: timeout with detector disabled is ignored
        mcd_timeout_i = 1'b1; tick(); mcd_timeout_i = 1'b0;
        settle();
        check("R10", "int_rst disabled", 32'(int_rst_o), 32'd0);
        tick(); settle();
        check("R10", "periph kept", 32'(periph_clk_en_o), 32'h70F);

        // R8: stop one cycle after the write, via detector exit (R10)
        wr(2'd2, NP'(3));
        check("R10", "mcd_en hook", 32'(mcd_en_o), 32'd1);
        wr(2'd3, NP'(2));
        settle();
        check("R8", "cpu still on", 32'(cpu_clk_en_o), 32'd1);
        check("R8", "osc still on", 32'(osc_en_o), 32'd1);
        tick(); settle();
        check("R8", "cpu off", 32'(cpu_clk_en_o), 32'd0);
        check("R8", "periph off", 32'(periph_clk_en_o), 32'd0);
        check("R8", "osc off", 32'(osc_en_o), 32'd0);

        // R9: wake and mode writes do not end stop
        wake_i = 1'b1; tick(); wake_i = 1'b0;
        wr(2'd3, NP'(0));
        wr(2'd2, NP'(0));
        settle();
        check("R9", "cpu", 32'(cpu_clk_en_o), 32'd0);
        check("R9", "periph", 32'(periph_clk_en_o), 32'd0);
        check("R9", "osc", 32'(osc_en_o), 32'd0);

        mcd_timeout_i = 1'b1; tick(); mcd_timeout_i = 1'b0;
        settle();
        check("R10", "int_rst pulse", 32'(int_rst_o), 32'd1);
        check("R10", "still stopped", 32'(cpu_clk_en_o), 32'd0);
        tick(); settle();
        check("R10", "int_rst ends", 32'(int_rst_o), 32'd0);
        check("R10", "cpu restored", 32'(cpu_clk_en_o), 32'd1);
        check("R10", "periph restored", 32'(periph_clk_en_o), 32'(ALL));
        check("R10", "osc restored", 32'(osc_en_o), 32'd1);
        check("R10", "mcd_en cleared", 32'(mcd_en_o), 32'd0);
        wr(2'd3, NP'(1));
        settle();
        check("R10", "masks reset, std idle", 32'(periph_clk_en_o), 32'(ALL));
        wake_i = 1'b1; tick(); wake_i = 1'b0;

        // R11: external reset ends stop
        wr(2'd2, NP'(1));
        wr(2'd0, '0);
        wr(2'd3, NP'(2));
        tick(); settle();
        check("R11", "stopped before reset", 32'(osc_en_o), 32'd0);
        #1 rst_n = 1'b0;
        #2;
        check("R11", "cpu in reset", 32'(cpu_clk_en_o), 32'd1);
        check("R11", "periph in reset", 32'(periph_clk_en_o), 32'(ALL));
        check("R11", "osc in reset", 32'(osc_en_o), 32'd1);
        tick();
        rst_n = 1'b1;
        tick(); settle();
        check("R11", "cpu after release", 32'(cpu_clk_en_o), 32'd1);

        done = 1'b1;
        finish_run();
    end

endmodule